// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the control and identification register set of a processor core module. A host reaches it through a simple 32-bit register bus: a byte address (registers sit on word boundaries and are selected by the address shifted right by two), a write enable, write data and read data. The block holds the main and auxiliary oscillator settings, the SDRAM and init words, a set/clear pair for a general flags word and another for a non-volatile flags word, and a 16-bit key register. Writes to the two oscillator registers are accepted only while the key holds the unlock value.

A control word drives a status LED and the boot-flash remap output, and it can issue a single-cycle system reset request. A small local interrupt unit holds one software-driven interrupt level bit and separate IRQ and FIQ enable masks, each with set and clear views, and it drives the IRQ and FIQ outputs. A read-only window at byte offsets 0x100 to 0x1FF returns bytes of a memory-module identification table, one byte per word, zero-extended.

Top module: `cm_sysctrl`

## Requirements
- R1: After reset the oscillator (index 2) reads 0x01000048, the auxiliary oscillator (index 7) 0x0007FEFF, SDRAM (index 8) 0x00011122 and init (index 9) 0x00000112; control, key, flags, non-volatile flags and both enable masks read zero, led_out is 0 and remap_flash_en is 1.
- R2: A write to index 5 stores bits 15:0 as the key; index 5 reads {15'b0, unlocked, key} where unlocked is 1 when the key equals 0xA05F. Writes to index 2 and index 7 change the register only while unlocked.
- R3: A write to index 3 keeps only bit 0 (drives led_out) and bit 2 (remap_flash_en is its inverse); index 3 reads those two bits in place and zero elsewhere.
- R4: A write to index 3 with bit 3 set makes sys_rst_req high for exactly the cycle after the write edge; bit 3 reads zero.
- R5: Index 12 ORs the write data into flags and index 13 clears the written ones; index 14 ORs into the non-volatile flags and index 15 clears; flags read at 12, non-volatile flags at 14.
- R6: Writes to index 8 and index 9 store the full 32-bit value, read back at the same index.
- R7: IRQ enable is ORed at index 18 and cleared (AND-NOT) at index 19, FIQ enable ORed at 26 and cleared at 27; the masks read at 18 and 26.
- R8: Writing index 20 with bit 0 set sets the interrupt level bit, writing index 21 with bit 0 set clears it; other bits do nothing. Index 20, 17 and 25 read the level in bit 0; index 16 reads level AND IRQ enable, index 24 level AND FIQ enable.
- R9: irq_out is high exactly when level AND IRQ enable is nonzero; fiq_out likewise with the FIQ enable.
- R10: A read at byte offset 0x100 to 0x1FF returns table entry (offset >> 2) in bits 7:0, upper bits zero; entries 73 to 83 hold the ASCII text "CORE-DIMM01" (73 holds 'C'), all other entries are zero; writes there change nothing.
- R11: Indices without a register (including 0, 1, 13, 15, 19, 21, 27 and 32 to 35) read zero and writes to them change no register.
- R12: Read data follows the address combinationally in the same cycle; writes take effect on the rising clock edge with write enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address; word index is bus_addr >> 2 |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| led_out | output | 1 | Status LED, control bit 0 |
| remap_flash_en | output | 1 | Boot flash mapped at address zero, inverse of control bit 2 |
| sys_rst_req | output | 1 | One-cycle system reset request |
| irq_out | output | 1 | Local IRQ request |
| fiq_out | output | 1 | Local FIQ request |

## Verification
The key gate is tried with oscillator writes while locked, after loading the unlock value, and after relocking with another value, which separates a gate that checks the stored key from one that latches once or ignores the key. Set/clear pairs are driven with overlapping bit patterns so OR, AND-NOT and plain overwrite give different results. The interrupt unit is driven with enable masks that include and exclude bit 0 and with soft-interrupt writes whose bit 0 is clear, telling masked status from raw level and bit-0-only action from whole-word action. The identification window is read at its first, last and text-boundary entries, exposing an off-by-one in indexing or byte order.

// File: rtl/cm_sysctrl_pkg.sv
package cm_sysctrl_pkg;

    localparam int unsigned DATA_W = 32;

    // word indices
    localparam int unsigned IX_OSC       = 2;
    localparam int unsigned IX_CTRL      = 3;
    localparam int unsigned IX_KEY       = 5;
    localparam int unsigned IX_AUX       = 7;
    localparam int unsigned IX_SDRAM     = 8;
    localparam int unsigned IX_INIT      = 9;
    localparam int unsigned IX_FLG_SET   = 12;
    localparam int unsigned IX_FLG_CLR   = 13;
    localparam int unsigned IX_NVF_SET   = 14;
    localparam int unsigned IX_NVF_CLR   = 15;
    localparam int unsigned IX_IRQ_STAT  = 16;
    localparam int unsigned IX_IRQ_RAW   = 17;
    localparam int unsigned IX_IRQ_ENS   = 18;
    localparam int unsigned IX_IRQ_ENC   = 19;
    localparam int unsigned IX_SOFT_SET  = 20;
    localparam int unsigned IX_SOFT_CLR  = 21;
    localparam int unsigned IX_FIQ_STAT  = 24;
    localparam int unsigned IX_FIQ_RAW   = 25;
    localparam int unsigned IX_FIQ_ENS   = 26;
    localparam int unsigned IX_FIQ_ENC   = 27;

    localparam logic [15:0] UNLOCK_KEY   = 16'hA05F;

    localparam logic [31:0] OSC_RST      = 32'h0100_0048;
    localparam logic [31:0] AUX_RST      = 32'h0007_FEFF;
    localparam logic [31:0] SDRAM_RST    = 32'h0001_1122;
    localparam logic [31:0] INIT_RST     = 32'h0000_0112;

    // identification text placed at table entries ID_FIRST..ID_FIRST+ID_LEN-1
    localparam int unsigned ID_FIRST     = 73;
    localparam int unsigned ID_LEN       = 11;
    localparam logic [8*ID_LEN-1:0] ID_TEXT = "CORE-DIMM01";

    typedef struct packed {
        logic [31:0] osc;
        logic [31:0] aux;
        logic [31:0] sdram;
        logic [31:0] init;
        logic [31:0] flags;
        logic [31:0] nvflags;
        logic [15:0] key;
        logic        led;
        logic        remap;
        logic        rst_req;
    } cfg_state_t;

    function automatic logic [7:0] id_byte(int unsigned ent);
        if (ent >= ID_FIRST && ent < ID_FIRST + ID_LEN)
            return ID_TEXT[8*(ID_FIRST + ID_LEN - 1 - ent) +: 8];
        return 8'h00;
    endfunction

endpackage

// File: rtl/cm_cfg_regs.sv
module cm_cfg_regs
    import cm_sysctrl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    output logic             led_out,
    output logic             remap_flash_en,
    output logic             sys_rst_req
);

    cfg_state_t st_d, st_q;
    logic       unlocked;
    logic [31:0] idx32;

    assign idx32    = 32'(idx);
    assign unlocked = (st_q.key == UNLOCK_KEY);

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (wr_en) begin
            case (idx32)
                IX_OSC:     if (unlocked) st_d.osc = wr_data;
                IX_AUX:     if (unlocked) st_d.aux = wr_data;
                IX_KEY:     st_d.key = wr_data[15:0];
                IX_CTRL: begin
                    st_d.led     = wr_data[0];
                    st_d.remap   = wr_data[2];
                    st_d.rst_req = wr_data[3];
                end
                IX_SDRAM:   st_d.sdram   = wr_data;
                IX_INIT:    st_d.init    = wr_data;
                IX_FLG_SET: st_d.flags   = st_q.flags | wr_data;
                IX_FLG_CLR: st_d.flags   = st_q.flags & ~wr_data;
                IX_NVF_SET: st_d.nvflags = st_q.nvflags | wr_data;
                IX_NVF_CLR: st_d.nvflags = st_q.nvflags & ~wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.osc     <= OSC_RST;
            st_q.aux     <= AUX_RST;
            st_q.sdram   <= SDRAM_RST;
            st_q.init    <= INIT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (idx32)
            IX_OSC:     rd_data = st_q.osc;
            IX_AUX:     rd_data = st_q.aux;
            IX_KEY:     rd_data = {15'b0, unlocked, st_q.key};
            IX_CTRL:    rd_data = {29'b0, st_q.remap, 1'b0, st_q.led};
            IX_SDRAM:   rd_data = st_q.sdram;
            IX_INIT:    rd_data = st_q.init;
            IX_FLG_SET: rd_data = st_q.flags;
            IX_NVF_SET: rd_data = st_q.nvflags;
            default:    rd_data = '0;
        endcase
    end

    assign led_out        = st_q.led;
    assign remap_flash_en = ~st_q.remap;
    assign sys_rst_req    = st_q.rst_req;

    // R2: oscillator unchanged by a write while the key is wrong
    p_osc_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx32 == IX_OSC && !unlocked) |=> $stable(st_q.osc))
        else $error("p_osc_locked_r2");

    // R4: a reset-request write gives a pulse on the next cycle
    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx32 == IX_CTRL && wr_data[3]) |=> sys_rst_req)
        else $error("p_rst_pulse_r4");

    // R5: every written bit is set after a flags set write
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx32 == IX_FLG_SET) |=> ((st_q.flags & $past(wr_data)) == $past(wr_data)))
        else $error("p_flag_set_r5");

endmodule

// File: rtl/cm_local_intc.sv
module cm_local_intc
    import cm_sysctrl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    output logic             level,
    output logic             irq_out,
    output logic             fiq_out
);

    typedef struct packed {
        logic        lvl;
        logic [31:0] irq_en;
        logic [31:0] fiq_en;
    } intc_state_t;

    intc_state_t st_d, st_q;
    logic [31:0] idx32;
    logic [31:0] lvl_w;

    assign idx32 = 32'(idx);
    assign lvl_w = {31'b0, st_q.lvl};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (idx32)
                IX_IRQ_ENS:  st_d.irq_en = st_q.irq_en | wr_data;
                IX_IRQ_ENC:  st_d.irq_en = st_q.irq_en & ~wr_data;
                IX_FIQ_ENS:  st_d.fiq_en = st_q.fiq_en | wr_data;
                IX_FIQ_ENC:  st_d.fiq_en = st_q.fiq_en & ~wr_data;
                IX_SOFT_SET: st_d.lvl    = st_q.lvl | wr_data[0];
                IX_SOFT_CLR: st_d.lvl    = st_q.lvl & ~wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (idx32)
            IX_IRQ_STAT: rd_data = lvl_w & st_q.irq_en;
            IX_FIQ_STAT: rd_data = lvl_w & st_q.fiq_en;
            IX_IRQ_RAW,
            IX_FIQ_RAW,
            IX_SOFT_SET: rd_data = lvl_w;
            IX_IRQ_ENS:  rd_data = st_q.irq_en;
            IX_FIQ_ENS:  rd_data = st_q.fiq_en;
            default:     rd_data = '0;
        endcase
    end

    assign level   = st_q.lvl;
    assign irq_out = |(lvl_w & st_q.irq_en);
    assign fiq_out = |(lvl_w & st_q.fiq_en);

    // R7: cleared enable bits are zero afterwards
    p_irq_en_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx32 == IX_IRQ_ENC) |=> ((st_q.irq_en & $past(wr_data)) == '0))
        else $error("p_irq_en_clr_r7");

    // R8: soft set with bit 0 raises the level
    p_soft_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx32 == IX_SOFT_SET && wr_data[0]) |=> level)
        else $error("p_soft_set_r8");

endmodule

// File: rtl/cm_id_window.sv
module cm_id_window
    import cm_sysctrl_pkg::*;
#(
    parameter int WIN_AW = 8
) (
    input  logic [WIN_AW-3:0] word_sel,
    output logic [31:0]       rd_data
);

    localparam int WORDS    = 2 ** (WIN_AW - 2);
    localparam int BASE_ENT = WORDS;

    logic [7:0] tab [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_ent
        assign tab[g] = id_byte(BASE_ENT + g);
    end

    assign rd_data = {24'b0, tab[word_sel]};

endmodule

// File: rtl/cm_sysctrl.sv
module cm_sysctrl
    import cm_sysctrl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              led_out,
    output logic              remap_flash_en,
    output logic              sys_rst_req,
    output logic              irq_out,
    output logic              fiq_out
);

    localparam int IDX_W  = ADDR_W - 2;
    localparam int WIN_AW = 8;

    logic [IDX_W-1:0] idx;
    logic             win_hit;
    logic [31:0]      cfg_rd, intc_rd, win_rd;
    logic             lvl;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign win_hit = (bus_addr[ADDR_W-1:WIN_AW] == (ADDR_W-WIN_AW)'(1));

    cm_cfg_regs #(.IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .idx(idx), .wr_data(bus_wdata),
        .rd_data(cfg_rd), .led_out(led_out), .remap_flash_en(remap_flash_en),
        .sys_rst_req(sys_rst_req)
    );

    cm_local_intc #(.IDX_W(IDX_W)) u_intc (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .idx(idx), .wr_data(bus_wdata),
        .rd_data(intc_rd), .level(lvl), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    cm_id_window #(.WIN_AW(WIN_AW)) u_win (
        .word_sel(bus_addr[WIN_AW-1:2]), .rd_data(win_rd)
    );

    assign bus_rdata = cfg_rd | intc_rd | (win_hit ? win_rd : 32'b0);

    // R3: remap output follows inverse of written bit 2
    p_remap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(idx) == IX_CTRL) |=> (remap_flash_en == !$past(bus_wdata[2])))
        else $error("p_remap_r3");

    // R3: control readback holds only bits 0 and 2
    p_ctrl_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(idx) == IX_CTRL) |-> (bus_rdata[31:3] == '0 && !bus_rdata[1]))
        else $error("p_ctrl_rd_r3");

    // R9: no request without a raised level
    p_no_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |-> (!irq_out && !fiq_out))
        else $error("p_no_lvl_r9");

    // R10: window reads are byte wide
    p_win_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> (bus_rdata[31:8] == '0))
        else $error("p_win_byte_r10");

endmodule

// File: tb/cm_sysctrl_bench.sv
module cm_sysctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        led_out, remap_flash_en, sys_rst_req, irq_out, fiq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cm_sysctrl u_cm_sysctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_out(led_out),
        .remap_flash_en(remap_flash_en), .sys_rst_req(sys_rst_req),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    // {req, we, addr, wdata, expected read}
    localparam int NV = 62;
    localparam logic [84:0] VEC [NV] = '{
        {8'd1,  1'b0, 12'h008, 32'h0, 32'h0100_0048},   // R1
        {8'd1,  1'b0, 12'h01C, 32'h0, 32'h0007_FEFF},
        {8'd1,  1'b0, 12'h020, 32'h0, 32'h0001_1122},
        {8'd1,  1'b0, 12'h024, 32'h0, 32'h0000_0112},
        {8'd2,  1'b1, 12'h008, 32'h1234_5678, 32'h0},    // R2 locked write
        {8'd2,  1'b0, 12'h008, 32'h0, 32'h0100_0048},
        {8'd2,  1'b1, 12'h014, 32'hFFFF_A05F, 32'h0},
        {8'd2,  1'b0, 12'h014, 32'h0, 32'h0001_A05F},
        {8'd2,  1'b1, 12'h008, 32'h1234_5678, 32'h0},
        {8'd2,  1'b0, 12'h008, 32'h0, 32'h1234_5678},
        {8'd2,  1'b1, 12'h01C, 32'h00AB_CDEF, 32'h0},
        {8'd2,  1'b0, 12'h01C, 32'h0, 32'h00AB_CDEF},
        {8'd2,  1'b1, 12'h014, 32'h0000_1234, 32'h0},
        {8'd2,  1'b0, 12'h014, 32'h0, 32'h0000_1234},
        {8'd2,  1'b1, 12'h01C, 32'h0, 32'h0},
        {8'd2,  1'b0, 12'h01C, 32'h0, 32'h00AB_CDEF},
        {8'd6,  1'b1, 12'h020, 32'hDEAD_BEEF, 32'h0},    // R6
        {8'd6,  1'b0, 12'h020, 32'h0, 32'hDEAD_BEEF},
        {8'd6,  1'b1, 12'h024, 32'hCAFE_F00D, 32'h0},
        {8'd6,  1'b0, 12'h024, 32'h0, 32'hCAFE_F00D},
        {8'd5,  1'b1, 12'h030, 32'h0000_F0F0, 32'h0},    // R5
        {8'd5,  1'b1, 12'h030, 32'h0000_000F, 32'h0},
        {8'd5,  1'b0, 12'h030, 32'h0, 32'h0000_F0FF},
        {8'd5,  1'b1, 12'h034, 32'h0000_00F0, 32'h0},
        {8'd5,  1'b0, 12'h030, 32'h0, 32'h0000_F00F},
        {8'd5,  1'b1, 12'h038, 32'hA500_0000, 32'h0},
        {8'd5,  1'b1, 12'h03C, 32'h0500_0000, 32'h0},
        {8'd5,  1'b0, 12'h038, 32'h0, 32'hA000_0000},
        {8'd11, 1'b0, 12'h03C, 32'h0, 32'h0},
        {8'd11, 1'b0, 12'h034, 32'h0, 32'h0},
        {8'd7,  1'b1, 12'h048, 32'h0000_000C, 32'h0},    // R7
        {8'd7,  1'b0, 12'h048, 32'h0, 32'h0000_000C},
        {8'd7,  1'b1, 12'h04C, 32'h0000_0004, 32'h0},
        {8'd7,  1'b0, 12'h048, 32'h0, 32'h0000_0008},
        {8'd11, 1'b0, 12'h04C, 32'h0, 32'h0},
        {8'd7,  1'b1, 12'h068, 32'h0000_0003, 32'h0},
        {8'd7,  1'b0, 12'h068, 32'h0, 32'h0000_0003},
        {8'd7,  1'b1, 12'h06C, 32'h0000_0001, 32'h0},
        {8'd7,  1'b0, 12'h068, 32'h0, 32'h0000_0002},
        {8'd8,  1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0},    // R8
        {8'd8,  1'b0, 12'h050, 32'h0, 32'h0000_0001},
        {8'd8,  1'b0, 12'h044, 32'h0, 32'h0000_0001},
        {8'd8,  1'b0, 12'h064, 32'h0, 32'h0000_0001},
        {8'd8,  1'b0, 12'h040, 32'h0, 32'h0},
        {8'd8,  1'b0, 12'h060, 32'h0, 32'h0},
        {8'd8,  1'b1, 12'h048, 32'h0000_0001, 32'h0},
        {8'd8,  1'b0, 12'h040, 32'h0, 32'h0000_0001},
        {8'd8,  1'b1, 12'h054, 32'hFFFF_FFFE, 32'h0},
        {8'd8,  1'b0, 12'h050, 32'h0, 32'h0000_0001},
        {8'd8,  1'b1, 12'h054, 32'h0000_0001, 32'h0},
        {8'd8,  1'b0, 12'h050, 32'h0, 32'h0},
        {8'd8,  1'b0, 12'h040, 32'h0, 32'h0},
        {8'd11, 1'b1, 12'h080, 32'hFFFF_FFFF, 32'h0},    // R11
        {8'd11, 1'b0, 12'h080, 32'h0, 32'h0},
        {8'd11, 1'b0, 12'h000, 32'h0, 32'h0},
        {8'd11, 1'b0, 12'h004, 32'h0, 32'h0},
        {8'd10, 1'b0, 12'h124, 32'h0, 32'h0000_0043},    // R10 'C'
        {8'd10, 1'b0, 12'h128, 32'h0, 32'h0000_004F},
        {8'd10, 1'b0, 12'h14C, 32'h0, 32'h0000_0031},
        {8'd10, 1'b0, 12'h120, 32'h0, 32'h0},
        {8'd10, 1'b0, 12'h150, 32'h0, 32'h0},
        {8'd10, 1'b0, 12'h1FC, 32'h0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state at the ports
        #1;
        chk("R1 led", {31'b0, led_out}, 32'd0);
        chk("R1 remap", {31'b0, remap_flash_en}, 32'd1);
        chk("R1 rstreq", {31'b0, sys_rst_req}, 32'd0);
        chk("R1 irq", {31'b0, irq_out}, 32'd0);
        chk("R1 fiq", {31'b0, fiq_out}, 32'd0);
        rd_chk("R1 ctrl", 12'h00C, 32'h0);
        rd_chk("R1 key", 12'h014, 32'h0);
        rd_chk("R1 irqen", 12'h048, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            v = VEC[i];
            @(negedge clk);
            bus_addr  = v[75:64];
            bus_we    = v[76];
            bus_wdata = v[63:32];
            if (!v[76]) begin
                #1 chk($sformatf("R%0d vec%0d", v[84:77], i), bus_rdata, v[31:0]);
            end
        end
        @(negedge clk);
        bus_we = 1'b0;

        // R10 writes into the window are ignored
        wr(12'h124, 32'h0);
        rd_chk("R10 win write", 12'h124, 32'h0000_0043);

        // R12 read follows address without a clock edge
        @(negedge clk);
        bus_addr = 12'h020; #0.5 chk("R12 a", bus_rdata, 32'hDEAD_BEEF);
        bus_addr = 12'h024; #0.5 chk("R12 b", bus_rdata, 32'hCAFE_F00D);

        // R3 control bits and outputs
        wr(12'h00C, 32'hFFFF_FFF7);
        #1;
        chk("R3 led", {31'b0, led_out}, 32'd1);
        chk("R3 remap", {31'b0, remap_flash_en}, 32'd0);
        rd_chk("R3 ctrl rd", 12'h00C, 32'h0000_0005);
        wr(12'h00C, 32'h0000_0001);
        #1 chk("R3 remap back", {31'b0, remap_flash_en}, 32'd1);

        // R4 reset request pulse
        @(negedge clk);
        bus_addr = 12'h00C; bus_we = 1'b1; bus_wdata = 32'h0000_0008;
        #1 chk("R4 before", {31'b0, sys_rst_req}, 32'd0);
        @(negedge clk);
        bus_we = 1'b0;
        #1 chk("R4 pulse", {31'b0, sys_rst_req}, 32'd1);
        @(negedge clk);
        #1 chk("R4 one cycle", {31'b0, sys_rst_req}, 32'd0);
        rd_chk("R4 bit3 reads 0", 12'h00C, 32'h0);

        // R9 request outputs (irq_en=9, fiq_en=2 at this point)
        wr(12'h050, 32'h1);
        #1;
        chk("R9 irq on", {31'b0, irq_out}, 32'd1);
        chk("R9 fiq off", {31'b0, fiq_out}, 32'd0);
        wr(12'h068, 32'h1);
        #1 chk("R9 fiq on", {31'b0, fiq_out}, 32'd1);
        wr(12'h04C, 32'h1);
        #1;
        chk("R9 irq masked", {31'b0, irq_out}, 32'd0);
        chk("R9 fiq stays", {31'b0, fiq_out}, 32'd1);
        wr(12'h054, 32'h1);
        #1 chk("R9 fiq off lvl", {31'b0, fiq_out}, 32'd0);

        done = 1;
        finish_run();
    end

endmodule